// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block is the digital controller of a successive-approximation analog-to-digital converter. It runs in the converter clock domain and takes one conversion from a start pulse to a finished 10-bit code. A conversion passes through three timed phases. In the first phase the chosen input reaches the sample capacitor through a buffer amplifier. In the second phase the buffer is bypassed and the multiplexer charges the capacitor directly. In the third phase the approximation register settles one bit per cycle, driven by a comparator decision.

The analog parts are abstract digital signals. The channel select drives a one-hot line set for a 16-input multiplexer. Two outputs control the buffer and the direct sampling switch. The comparator is a single input bit that reports whether the current trial code is above the sampled voltage. A 2-bit code sets the length of the direct phase. The code and the channel are both captured when the start pulse is accepted. A stop request or the synchronous reset returns the controller to idle at the next clock edge.

Top module: `sar_conv_seq`

## Requirements
- R1: While reset is asserted and after it is released with no start, busy, eoc, buf_en and direct_en are low, mux_en is all zero, sar is zero and chan_q is zero.
- R2: A start that is accepted (controller idle, stop low) makes busy and buf_en high at the next edge. buf_en then stays high for exactly 2 cycles and direct_en is low during those cycles.
- R3: The 2 buffered cycles are followed by a direct phase with direct_en high and buf_en low. Its length is 2 cycles for code 00, 4 for 01, 8 for 10 and 16 for 11. buf_en and direct_en are never high in the same cycle.
- R4: sar is zero during both sample phases. Resolution then takes 10 cycles, from bit 9 (MSB) down to bit 0. In each cycle the trial bit is set, and it is cleared at the edge if comp_above is 1, meaning the trial code is above the input. With a comparator that reports sar > V, the final code equals V.
- R5: eoc is a one-cycle pulse in the cycle right after the 10th resolution cycle. It comes 2 + L + 10 cycles after the first sample cycle (14 to 28), where L is the direct phase length. sar holds the final code in that cycle.
- R6: busy is high from the cycle after an accepted start up to and including the eoc cycle, and low in the cycle after eoc.
- R7: chan_q takes the 6-bit channel at the accepted start and holds it until the next accepted start. When chan_q is below 16, mux_en has exactly bit chan_q[3:0] set during the buffered and direct phases, and it is zero in every other cycle.
- R8: When chan_q is 16 or greater (upper two bits not both zero), mux_en stays all zero for the whole conversion.
- R9: A start that arrives while busy is high is ignored. The running conversion keeps its original timing, channel and code.
- R10: stop high at an edge makes the next cycle idle: busy, eoc, buf_en and direct_en are low, mux_en is zero and sar is zero. No eoc follows for the aborted conversion.
- R11: rst high at an edge during a conversion aborts it in the same way as stop, and no eoc follows.
- R12: After eoc, sar keeps the final code until the next accepted start or abort.
- R13: start and stop high in the same cycle while idle leave the controller idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Conversion request, sampled at each edge |
| stop | input | 1 | Abort request, returns the controller to idle |
| ist | input | 2 | Direct sample length code (00:2, 01:4, 10:8, 11:16 cycles) |
| chan | input | 6 | Channel number captured at start |
| comp_above | input | 1 | Comparator: 1 when the trial code is above the sampled input |
| busy | output | 1 | Conversion in progress, including the eoc cycle |
| buf_en | output | 1 | Buffered sample phase: buffer amplifier enabled |
| direct_en | output | 1 | Direct sample phase: bypass switch closed |
| mux_en | output | 16 | One-hot multiplexer line select |
| chan_q | output | 6 | Captured channel number |
| sar | output | 10 | Approximation register; final code at eoc |
| eoc | output | 1 | End-of-conversion pulse |

## Verification
The bench builds the controller with its default parameters: a 10-bit register, a 2-cycle buffered phase, a base direct length of 2 with a 2-bit code, a 6-bit channel and 16 multiplexer lines. With these values all four direct phase lengths can be tested, so conversions from 14 to 28 cycles are covered, along with codes at both ends of the range and channels above the multiplexer range. Directed runs place a second start, a stop and a reset inside the direct and resolution phases, to check that aborts take effect within one cycle and that a second start has no effect.

// File: rtl/sar_conv_seq_pkg.sv
package sar_conv_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_BUF   = 3'd1,
        PH_DIR   = 3'd2,
        PH_RES   = 3'd3,
        PH_DONE  = 3'd4
    } phase_e;

    typedef struct packed {
        logic busy;
        logic buf_en;
        logic direct_en;
        logic resolving;
        logic done;
    } phase_ctl_t;

    // Direct sample length: base doubled once per code step.
    function automatic int unsigned direct_len(input int unsigned base,
                                               input int unsigned code);
        return base << code;
    endfunction

    function automatic phase_ctl_t phase_decode(input phase_e ph);
        phase_ctl_t c;
        c.busy      = (ph != PH_IDLE);
        c.buf_en    = (ph == PH_BUF);
        c.direct_en = (ph == PH_DIR);
        c.resolving = (ph == PH_RES);
        c.done      = (ph == PH_DONE);
        return c;
    endfunction

endpackage

// File: rtl/sar_conv_seq_timer.sv
module sar_conv_seq_timer
    import sar_conv_seq_pkg::*;
#(
    parameter int BUF_CYC  = 2,
    parameter int DIR_BASE = 2,
    parameter int CODE_W   = 2,
    parameter int RES_BITS = 10,
    parameter int CNT_W    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              stop,
    input  logic [CODE_W-1:0] code,
    output phase_e            phase,
    output logic [CNT_W-1:0]  cnt,
    output logic              accept,
    output logic              enter_res
);

    phase_e            ph_n;
    logic [CNT_W-1:0]  cnt_n;
    logic [CODE_W-1:0] code_q;

    assign accept    = (phase == PH_IDLE) && start && !stop;
    assign enter_res = (phase == PH_DIR) && (cnt == '0) && !stop;

    always_comb begin
        ph_n  = phase;
        cnt_n = cnt;
        case (phase)
            PH_IDLE: begin
                if (start) begin
                    ph_n  = PH_BUF;
                    cnt_n = CNT_W'(BUF_CYC - 1);
                end
            end
            PH_BUF: begin
                if (cnt == '0) begin
                    ph_n  = PH_DIR;
                    cnt_n = CNT_W'(direct_len(DIR_BASE, 32'(code_q)) - 1);
                end else begin
                    cnt_n = cnt - 1'b1;
                end
            end
            PH_DIR: begin
                if (cnt == '0) begin
                    ph_n  = PH_RES;
                    cnt_n = CNT_W'(RES_BITS - 1);
                end else begin
                    cnt_n = cnt - 1'b1;
                end
            end
            PH_RES: begin
                if (cnt == '0) begin
                    ph_n = PH_DONE;
                end else begin
                    cnt_n = cnt - 1'b1;
                end
            end
            default: begin
                ph_n  = PH_IDLE;
                cnt_n = '0;
            end
        endcase
        if (stop) begin
            ph_n  = PH_IDLE;
            cnt_n = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            code_q <= '0;
        end else begin
            phase <= ph_n;
            cnt   <= cnt_n;
            if (accept) begin
                code_q <= code;
            end
        end
    end

endmodule

// File: rtl/sar_conv_seq_approx.sv
module sar_conv_seq_approx #(
    parameter int RES_BITS = 10,
    parameter int IDX_W    = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clear,
    input  logic                load_msb,
    input  logic                step,
    input  logic [IDX_W-1:0]    bit_idx,
    input  logic                comp_above,
    output logic [RES_BITS-1:0] value
);

    logic [RES_BITS-1:0] nxt;

    // Decide the trial bit, then raise the next lower one.
    always_comb begin
        nxt = value;
        for (int i = 0; i < RES_BITS; i++) begin
            if (i == int'(bit_idx) && comp_above) begin
                nxt[i] = 1'b0;
            end
            if (i + 1 == int'(bit_idx)) begin
                nxt[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            value <= '0;
        end else if (load_msb) begin
            value <= {1'b1, {(RES_BITS-1){1'b0}}};
        end else if (step) begin
            value <= nxt;
        end
    end

endmodule

// File: rtl/sar_conv_seq_chan.sv
module sar_conv_seq_chan #(
    parameter int SEL_W = 6,
    parameter int MUX_N = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic [SEL_W-1:0] chan,
    input  logic             sampling,
    output logic [SEL_W-1:0] chan_q,
    output logic [MUX_N-1:0] mux_en
);

    localparam int LINE_W = $clog2(MUX_N);

    logic in_range;

    always_ff @(posedge clk) begin
        if (rst) begin
            chan_q <= '0;
        end else if (accept) begin
            chan_q <= chan;
        end
    end

    assign in_range = (chan_q[SEL_W-1:LINE_W] == '0);

    for (genvar g = 0; g < MUX_N; g++) begin : g_line
        assign mux_en[g] = sampling && in_range &&
                           (chan_q[LINE_W-1:0] == LINE_W'(g));
    end

endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
    import sar_conv_seq_pkg::*;
#(
    parameter int RES_BITS = 10,
    parameter int BUF_CYC  = 2,
    parameter int DIR_BASE = 2,
    parameter int CODE_W   = 2,
    parameter int SEL_W    = 6,
    parameter int MUX_N    = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                stop,
    input  logic [CODE_W-1:0]   ist,
    input  logic [SEL_W-1:0]    chan,
    input  logic                comp_above,
    output logic                busy,
    output logic                buf_en,
    output logic                direct_en,
    output logic [MUX_N-1:0]    mux_en,
    output logic [SEL_W-1:0]    chan_q,
    output logic [RES_BITS-1:0] sar,
    output logic                eoc
);

    localparam int MAX_DIR = DIR_BASE << ((1 << CODE_W) - 1);
    localparam int MAX_A   = (MAX_DIR > RES_BITS) ? MAX_DIR : RES_BITS;
    localparam int MAX_CNT = (MAX_A > BUF_CYC) ? MAX_A : BUF_CYC;
    localparam int CNT_W   = $clog2(MAX_CNT);
    localparam int IDX_W   = $clog2(RES_BITS);

    phase_e           phase;
    phase_ctl_t       ctl;
    logic [CNT_W-1:0] cnt;
    logic             accept;
    logic             enter_res;

    sar_conv_seq_timer #(
        .BUF_CYC (BUF_CYC),
        .DIR_BASE(DIR_BASE),
        .CODE_W  (CODE_W),
        .RES_BITS(RES_BITS),
        .CNT_W   (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .stop     (stop),
        .code     (ist),
        .phase    (phase),
        .cnt      (cnt),
        .accept   (accept),
        .enter_res(enter_res)
    );

    assign ctl = phase_decode(phase);

    sar_conv_seq_approx #(
        .RES_BITS(RES_BITS),
        .IDX_W   (IDX_W)
    ) u_approx (
        .clk       (clk),
        .rst       (rst),
        .clear     (accept || stop),
        .load_msb  (enter_res),
        .step      (ctl.resolving),
        .bit_idx   (cnt[IDX_W-1:0]),
        .comp_above(comp_above),
        .value     (sar)
    );

    sar_conv_seq_chan #(
        .SEL_W(SEL_W),
        .MUX_N(MUX_N)
    ) u_chan (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .chan    (chan),
        .sampling(ctl.buf_en || ctl.direct_en),
        .chan_q  (chan_q),
        .mux_en  (mux_en)
    );

    assign busy      = ctl.busy;
    assign buf_en    = ctl.buf_en;
    assign direct_en = ctl.direct_en;
    assign eoc       = ctl.done;

endmodule

// File: rtl/sar_conv_seq_chk.sv
module sar_conv_seq_chk #(
    parameter int RES_BITS = 10,
    parameter int CODE_W   = 2,
    parameter int SEL_W    = 6,
    parameter int MUX_N    = 16
) (
    input logic                clk,
    input logic                rst,
    input logic                start,
    input logic                stop,
    input logic [CODE_W-1:0]   ist,
    input logic [SEL_W-1:0]    chan,
    input logic                comp_above,
    input logic                busy,
    input logic                buf_en,
    input logic                direct_en,
    input logic [MUX_N-1:0]    mux_en,
    input logic [SEL_W-1:0]    chan_q,
    input logic [RES_BITS-1:0] sar,
    input logic                eoc
);

    a_r2_start_enters_buffer: assert property (@(posedge clk) disable iff (rst)
        (start && !stop && !busy) |=> (buf_en && busy));

    a_r3_phase_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(buf_en && direct_en));

    a_r4_sar_clear_sampling: assert property (@(posedge clk) disable iff (rst)
        (buf_en || direct_en) |-> (sar == '0));

    a_r5_eoc_single: assert property (@(posedge clk) disable iff (rst)
        eoc |=> !eoc);

    a_r6_busy_at_eoc: assert property (@(posedge clk) disable iff (rst)
        eoc |-> busy);

    a_r6_idle_after_eoc: assert property (@(posedge clk) disable iff (rst)
        eoc |=> !busy);

    a_r7_mux_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(mux_en));

    a_r7_mux_only_sampling: assert property (@(posedge clk) disable iff (rst)
        (mux_en != '0) |-> (buf_en || direct_en));

    a_r9_chan_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && !stop && !eoc) |=> $stable(chan_q));

    a_r10_stop_idle: assert property (@(posedge clk) disable iff (rst)
        stop |=> (!busy && !buf_en && !direct_en && !eoc &&
                  mux_en == '0 && sar == '0));

    a_r11_reset_idle: assert property (@(posedge clk)
        rst |=> (!busy && !eoc && sar == '0));

endmodule

bind sar_conv_seq sar_conv_seq_chk #(
    .RES_BITS(RES_BITS),
    .CODE_W  (CODE_W),
    .SEL_W   (SEL_W),
    .MUX_N   (MUX_N)
) u_chk (.*);

// File: tb/sar_conv_seq_bench.sv
module sar_conv_seq_bench;

    localparam int RB = 10;
    localparam int CW = 2;
    localparam int SW = 6;
    localparam int MN = 16;

    // {code[17:16], chan[15:10], value[9:0]}
    localparam logic [17:0] VEC [8] = '{
        {2'b00, 6'd5,  10'd683},
        {2'b01, 6'd15, 10'd0},
        {2'b10, 6'd0,  10'd1023},
        {2'b11, 6'd7,  10'd512},
        {2'b00, 6'd20, 10'd511},
        {2'b11, 6'd63, 10'd1},
        {2'b10, 6'd9,  10'd300},
        {2'b01, 6'd12, 10'd1022}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          stop = 1'b0;
    logic [CW-1:0] ist = '0;
    logic [SW-1:0] chan = '0;
    logic          comp_above;
    logic          busy, buf_en, direct_en, eoc;
    logic [MN-1:0] mux_en;
    logic [SW-1:0] chan_q;
    logic [RB-1:0] sar;
    logic [RB-1:0] vin = '0;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    // Analog model: trial code above the held input voltage.
    assign comp_above = (sar > vin);

    sar_conv_seq u_sar_conv_seq (
        .clk(clk), .rst(rst), .start(start), .stop(stop), .ist(ist),
        .chan(chan), .comp_above(comp_above), .busy(busy), .buf_en(buf_en),
        .direct_en(direct_en), .mux_en(mux_en), .chan_q(chan_q), .sar(sar),
        .eoc(eoc)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // kind: 0 plain, 1 second start at cycle d, 2 stop at d, 3 reset at d
    task automatic conv(input logic [CW-1:0] c_v, input logic [SW-1:0] ch_v,
                        input logic [RB-1:0] v, input int kind, input int d);
        int len = 2 << c_v;
        int eoc_at = 13 + len;
        int last = (kind >= 2) ? d : eoc_at;
        int nb = 0, nd = 0, ne = 0, first_eoc = 0;
        int ph_bad = 0, busy_bad = 0, mux_bad = 0, chan_bad = 0;
        int hold_bad = 0, abort_bad = 0;
        logic [RB-1:0] res = '0;
        @(negedge clk);
        vin = v; ist = c_v; chan = ch_v; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int c = 1; c <= 40; c++) begin
            bit e_buf = (c <= 2) && (c <= last);
            bit e_dir = (c > 2) && (c <= 2 + len) && (c <= last);
            bit e_busy = (c <= last);
            logic [MN-1:0] e_mux = ((e_buf || e_dir) && ch_v < 6'd16) ?
                                   (MN'(1) << ch_v[3:0]) : '0;
            start = 1'b0; stop = 1'b0; rst = 1'b0;
            ist = c_v; chan = ch_v;
            if (buf_en) nb++;
            if (direct_en) nd++;
            if (eoc) begin
                ne++;
                if (first_eoc == 0) begin
                    first_eoc = c;
                    res = sar;
                end
            end
            if (buf_en != e_buf || direct_en != e_dir) ph_bad++;
            if (busy != e_busy) busy_bad++;
            if (mux_en != e_mux) mux_bad++;
            if (e_busy && chan_q != ch_v) chan_bad++;
            if (kind < 2 && c > eoc_at && sar != v) hold_bad++;
            if (kind >= 2 && c > d &&
                (busy || eoc || buf_en || direct_en || mux_en != '0 || sar != '0))
                abort_bad++;
            if (c == d && kind == 1) begin
                start = 1'b1; ist = ~c_v; chan = ch_v ^ 6'd1;
            end
            if (c == d && kind == 2) stop = 1'b1;
            if (c == d && kind == 3) rst = 1'b1;
            @(negedge clk);
        end
        stop = 1'b0; rst = 1'b0;
        if (kind < 2) begin
            check(nb == 2, "R2", "buffered cycles", nb, 2);
            check(nd == len, "R3", "direct cycles", nd, len);
            check(ph_bad == 0, "R3", "phase order errors", ph_bad, 0);
            check(first_eoc == eoc_at, "R5", "eoc cycle", first_eoc, eoc_at);
            check(ne == 1, "R5", "eoc pulses", ne, 1);
            check(res == v, "R4", "final code", int'(res), int'(v));
            check(busy_bad == 0, "R6", "busy errors", busy_bad, 0);
            check(hold_bad == 0, "R12", "code hold errors", hold_bad, 0);
            if (kind == 1)
                check(chan_bad == 0 && first_eoc == eoc_at, "R9",
                      "second start disturbed", chan_bad, 0);
            else
                check(chan_bad == 0, "R7", "channel hold errors", chan_bad, 0);
            if (ch_v >= 6'd16)
                check(mux_bad == 0, "R8", "out-of-range mux errors", mux_bad, 0);
            else
                check(mux_bad == 0, "R7", "mux select errors", mux_bad, 0);
        end else begin
            check(ne == 0, kind == 2 ? "R10" : "R11", "eoc after abort", ne, 0);
            check(abort_bad == 0, kind == 2 ? "R10" : "R11",
                  "outputs after abort", abort_bad, 0);
            check(ph_bad == 0 && busy_bad == 0, kind == 2 ? "R10" : "R11",
                  "phase before abort", ph_bad + busy_bad, 0);
        end
    endtask

    initial begin
        #(20 * 20000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !eoc && !buf_en && !direct_en && mux_en == '0 &&
              sar == '0 && chan_q == '0, "R1", "state under reset",
              int'(busy), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check(!busy && !eoc && !buf_en && !direct_en && mux_en == '0 &&
              sar == '0, "R1", "idle after reset", int'(busy), 0);

        for (int i = 0; i < 8; i++) begin
            conv(VEC[i][17:16], VEC[i][15:10], VEC[i][9:0], 0, 0);
        end

        // R9: second start during the direct phase
        conv(2'b00, 6'd3, 10'd100, 1, 3);
        // R10: stop during the direct phase
        conv(2'b01, 6'd6, 10'd77, 2, 5);
        // R11: reset during resolution
        conv(2'b00, 6'd2, 10'd900, 3, 8);
        // recovery after abort
        conv(2'b11, 6'd4, 10'd345, 0, 0);

        // R13: start and stop together while idle
        @(negedge clk);
        start = 1'b1; stop = 1'b1;
        @(negedge clk);
        start = 1'b0; stop = 1'b0;
        check(!busy && !buf_en, "R13", "busy after start+stop", int'(busy), 0);
        repeat (3) @(negedge clk);
        check(!busy && !eoc, "R13", "still idle", int'(busy), 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule